// File: doc/BRIEF.md
# LIN Transmitter Fault Supervisor

This block sits between a LIN node's transmit data path and its bus driver. It decides, cycle by cycle, whether the driver may act on the transmit data. It watches five things: the transmit data, the bus level, the receive level, a digital thermal-overload flag and a permit from the mode controller. From these it detects four conditions: transmit data held dominant too long, the bus held dominant too long, a receive-level mismatch while the bus is recessive, and thermal overload. When any of them is present, it turns the driver off and forces the data seen by the driver to recessive.

Each fault source has its own way of clearing. A transmit-dominant timeout clears only after transmit data has been sampled high again. A bus-dominant timeout clears only when the bus is recessive while the mode controller still permits transmission. The receive-mismatch and thermal faults clear as soon as their cause goes away. The fault is reported in two forms. The first is a plain flag. The second is an active-low indication, held inactive for a blanking window after each falling edge of transmit data so that propagation delay cannot cause a false report. A one-cycle pulse marks the cycle in which the last active fault clears.

Top module: `lin_tx_guard`

## Requirements
- R1: During reset and in the first cycle after it, `fault` is 0, `fault_n` is 1, `fault_clear` is 0 and `txd_eff` is 1, while `tx_en` equals `tx_allow`.
- R2: `txd_in`, `bus_in`, `rxd_in` and `therm_in` each pass through a two-flop synchronizer. A change driven on one of them reaches the outputs two clock edges later. Level 1 is recessive on `txd_in` and `bus_in`, and level 1 on `rxd_in` means the receiver reads high.
- R3: When the synchronized transmit data is low for `TXD_TO` consecutive samples, a transmit timeout fault is raised on the clock edge that takes in the `TXD_TO`-th low sample.
- R4: A transmit timeout fault stays set while transmit data stays low. It clears on the edge that follows the first sample of transmit data back high.
- R5: When the synchronized bus is dominant (0) for `BUS_TO` consecutive samples, a bus timeout fault is raised. Any recessive bus sample resets the count.
- R6: A bus timeout fault clears only on an edge where the bus sample is recessive and `tx_allow` is 1. While `tx_allow` is 0 it stays set, even with the bus recessive.
- R7: When the synchronized bus is recessive but the synchronized receive level is low, a receive fault is present. This covers bus contention and receive monitoring. The fault goes away as soon as either condition ends.
- R8: While the synchronized thermal flag is 1, a thermal fault is present. It clears on its own once the flag returns to 0.
- R9: `fault` is the OR of the four fault sources. `tx_en` is 1 only when `tx_allow` is 1 and `fault` is 0. `txd_eff` equals the synchronized transmit data while `tx_en` is 1, and is forced to 1 otherwise.
- R10: `fault_n` is 0 only while `fault` is 1 and no blanking window is running. A window of `BLANK` cycles starts on the edge after a falling edge of synchronized transmit data is seen.
- R11: `fault_clear` is 1 for exactly the one cycle in which `fault` has just gone from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_in | input | 1 | Transmit data from the controller, 0 dominant |
| bus_in | input | 1 | Sampled bus level, 0 dominant |
| rxd_in | input | 1 | Receive-level check, 1 when the receiver reads high |
| therm_in | input | 1 | Thermal overload flag, 1 when overheated |
| tx_allow | input | 1 | Transmit permit from the mode controller (synchronous) |
| tx_en | output | 1 | Driver enable gate |
| txd_eff | output | 1 | Transmit data delivered to the driver |
| fault | output | 1 | Any fault source active |
| fault_n | output | 1 | Active-low fault indication after blanking; 0 means pull the pin low |
| fault_clear | output | 1 | One-cycle pulse when all faults have cleared |

## Verification
Outputs that follow an asynchronous input are due two edges after the drive. Timeouts are due `TO`+2 edges after the input goes dominant. Latched timeouts clear three edges after the input returns, or one edge after `tx_allow` rises for the bus case, and `tx_allow` acts on `tx_en` in the same cycle. The bench drives inputs just after a falling clock edge. For each stimulus it queues the expected output set with the exact cycle number at which it is due, including the cycle just before each timeout fires. A monitor compares the head of the queue on the falling edge of that cycle. The blanking window is checked at its first cycle, its last cycle and the cycle after it.

// File: rtl/lin_tx_guard.sv
module lin_tx_guard #(
  parameter int TXD_TO = 1250000,
  parameter int BUS_TO = 1250000,
  parameter int BLANK  = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_in,
  input  logic bus_in,
  input  logic rxd_in,
  input  logic therm_in,
  input  logic tx_allow,
  output logic tx_en,
  output logic txd_eff,
  output logic fault,
  output logic fault_n,
  output logic fault_clear
);
  localparam int TW = $clog2(TXD_TO + 1);
  localparam int BW = $clog2(BUS_TO + 1);
  localparam int KW = $clog2(BLANK + 1);
  localparam logic [TW-1:0] TXD_MAX  = TW'(TXD_TO);
  localparam logic [TW-1:0] TXD_LAST = TW'(TXD_TO - 1);
  localparam logic [BW-1:0] BUS_MAX  = BW'(BUS_TO);
  localparam logic [BW-1:0] BUS_LAST = BW'(BUS_TO - 1);
  localparam logic [KW-1:0] BLANK_K  = KW'(BLANK);

  logic [1:0] txd_m, bus_m, rxd_m, th_m;
  logic txd_s, bus_s, rxd_s, therm_s, txd_prev;
  logic [TW-1:0] txd_cnt;
  logic [BW-1:0] bus_cnt;
  logic [KW-1:0] blank_cnt;
  logic txd_to, bus_to, rx_flt, fault_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      txd_m <= 2'b11; bus_m <= 2'b11; rxd_m <= 2'b11; th_m <= 2'b00;
      txd_prev <= 1'b1;
    end else begin
      txd_m <= {txd_m[0], txd_in};
      bus_m <= {bus_m[0], bus_in};
      rxd_m <= {rxd_m[0], rxd_in};
      th_m  <= {th_m[0], therm_in};
      txd_prev <= txd_s;
    end

  assign txd_s   = txd_m[1];
  assign bus_s   = bus_m[1];
  assign rxd_s   = rxd_m[1];
  assign therm_s = th_m[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      txd_cnt <= '0; txd_to <= 1'b0;
    end else if (txd_s) begin
      txd_cnt <= '0; txd_to <= 1'b0;
    end else begin
      if (txd_cnt != TXD_MAX) txd_cnt <= txd_cnt + 1'b1;
      if (txd_cnt == TXD_LAST) txd_to <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_cnt <= '0; bus_to <= 1'b0;
    end else if (bus_s) begin
      bus_cnt <= '0;
      if (tx_allow) bus_to <= 1'b0;
    end else begin
      if (bus_cnt != BUS_MAX) bus_cnt <= bus_cnt + 1'b1;
      if (bus_cnt == BUS_LAST) bus_to <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) blank_cnt <= '0;
    else if (txd_prev && !txd_s) blank_cnt <= BLANK_K;
    else if (blank_cnt != '0) blank_cnt <= blank_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fault_d <= 1'b0;
    else fault_d <= fault;

  assign rx_flt      = bus_s & ~rxd_s;
  assign fault       = txd_to | bus_to | rx_flt | therm_s;
  assign tx_en       = tx_allow & ~fault;
  assign txd_eff     = tx_en ? txd_s : 1'b1;
  assign fault_n     = ~(fault && blank_cnt == '0);
  assign fault_clear = fault_d & ~fault;
endmodule

// File: rtl/lin_tx_guard_chk.sv
module lin_tx_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_allow,
  input logic tx_en,
  input logic fault,
  input logic fault_n,
  input logic fault_clear,
  input logic txd_s,
  input logic bus_s,
  input logic txd_to,
  input logic bus_to
);
  AST_FAULT_GATES: assert property (@(posedge clk) disable iff (!rst_n) fault |-> !tx_en); // R9
  AST_IND_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n) !fault_n |-> fault); // R10
  AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(fault) |-> fault_clear); // R11
  AST_CLEAR_ONLY_FALL: assert property (@(posedge clk) disable iff (!rst_n) fault_clear |-> (!fault && $past(fault))); // R11
  AST_TXD_TO_SET: assert property (@(posedge clk) disable iff (!rst_n) $rose(txd_to) |-> !$past(txd_s)); // R3
  AST_TXD_TO_CLR: assert property (@(posedge clk) disable iff (!rst_n) $fell(txd_to) |-> $past(txd_s)); // R4
  AST_BUS_TO_SET: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_to) |-> !$past(bus_s)); // R5
  AST_BUS_TO_CLR: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_to) |-> ($past(bus_s) && $past(tx_allow))); // R6
endmodule

bind lin_tx_guard lin_tx_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_allow(tx_allow), .tx_en(tx_en),
  .fault(fault), .fault_n(fault_n), .fault_clear(fault_clear),
  .txd_s(txd_s), .bus_s(bus_s), .txd_to(txd_to), .bus_to(bus_to)
);

// File: tb/lin_tx_guard_tb_top.sv
module lin_tx_guard_tb_top;
  localparam int TXD_TO = 20;
  localparam int BUS_TO = 30;
  localparam int BLANK  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txd_in = 1'b1, bus_in = 1'b1, rxd_in = 1'b1, therm_in = 1'b0, tx_allow = 1'b1;
  logic tx_en, txd_eff, fault, fault_n, fault_clear;
  int cyc = 0, t0 = 0, checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    int    at;
    logic  en, eff, flt, fn, clr;
    string tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lin_tx_guard #(.TXD_TO(TXD_TO), .BUS_TO(BUS_TO), .BLANK(BLANK)) dut_i (
    .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .bus_in(bus_in), .rxd_in(rxd_in),
    .therm_in(therm_in), .tx_allow(tx_allow), .tx_en(tx_en), .txd_eff(txd_eff),
    .fault(fault), .fault_n(fault_n), .fault_clear(fault_clear));

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({tx_en, txd_eff, fault, fault_n, fault_clear} !== {e.en, e.eff, e.flt, e.fn, e.clr}) begin
        errors++;
        $display("FAIL %s cycle %0d: en/eff/flt/fn/clr actual %b%b%b%b%b expected %b%b%b%b%b",
                 e.tag, cyc, tx_en, txd_eff, fault, fault_n, fault_clear,
                 e.en, e.eff, e.flt, e.fn, e.clr);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic mark();
    t0 = cyc;
  endtask

  task automatic expect_at(input int d, input logic en, input logic eff, input logic flt,
                           input logic fn, input logic clr, input string tag);
    exp_t e;
    e.at = t0 + d; e.en = en; e.eff = eff; e.flt = flt; e.fn = fn; e.clr = clr; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    #1;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1; mark();
    expect_at(1, 1, 1, 0, 1, 0, "R1"); drain();

    txd_in = 0; bus_in = 0; rxd_in = 0; mark();
    expect_at(1, 1, 1, 0, 1, 0, "R2");
    expect_at(2, 1, 0, 0, 1, 0, "R2"); drain(); step(2);
    txd_in = 1; bus_in = 1; rxd_in = 1; mark();
    expect_at(2, 1, 1, 0, 1, 0, "R2"); drain(); step(3);

    txd_in = 0; mark();
    expect_at(TXD_TO + 1, 1, 0, 0, 1, 0, "R3");
    expect_at(TXD_TO + 2, 0, 1, 1, 0, 0, "R3 R9"); drain(); step(5);
    txd_in = 1; mark();
    expect_at(2, 0, 1, 1, 0, 0, "R4");
    expect_at(3, 1, 1, 0, 1, 1, "R4 R11");
    expect_at(4, 1, 1, 0, 1, 0, "R11"); drain(); step(2);

    therm_in = 1; mark();
    expect_at(2, 0, 1, 1, 0, 0, "R8"); drain();
    txd_in = 0; mark();
    expect_at(2, 0, 1, 1, 0, 0, "R10");
    expect_at(3, 0, 1, 1, 1, 0, "R10");
    expect_at(BLANK + 2, 0, 1, 1, 1, 0, "R10");
    expect_at(BLANK + 3, 0, 1, 1, 0, 0, "R10"); drain();
    txd_in = 1; step(4);
    therm_in = 0; mark();
    expect_at(1, 0, 1, 1, 0, 0, "R8");
    expect_at(2, 1, 1, 0, 1, 1, "R8 R11");
    expect_at(3, 1, 1, 0, 1, 0, "R11"); drain(); step(2);

    bus_in = 0; rxd_in = 0; mark();
    expect_at(BUS_TO + 1, 1, 1, 0, 1, 0, "R5");
    expect_at(BUS_TO + 2, 0, 1, 1, 0, 0, "R5"); drain();
    tx_allow = 0; bus_in = 1; rxd_in = 1; mark();
    expect_at(4, 0, 1, 1, 0, 0, "R6"); drain(); step(2);
    tx_allow = 1; mark();
    expect_at(1, 1, 1, 0, 1, 1, "R6"); drain(); step(2);

    bus_in = 0; rxd_in = 0; step(BUS_TO - 5);
    bus_in = 1; rxd_in = 1; step(3);
    bus_in = 0; rxd_in = 0; mark();
    expect_at(BUS_TO, 1, 1, 0, 1, 0, "R5");
    expect_at(BUS_TO + 1, 1, 1, 0, 1, 0, "R5"); drain();
    bus_in = 1; rxd_in = 1; step(4);

    rxd_in = 0; mark();
    expect_at(2, 0, 1, 1, 0, 0, "R7"); drain();
    rxd_in = 1; mark();
    expect_at(2, 1, 1, 0, 1, 1, "R7"); drain(); step(2);

    txd_in = 0; mark();
    expect_at(2, 1, 0, 0, 1, 0, "R9"); drain();
    tx_allow = 0; mark();
    expect_at(1, 0, 1, 0, 1, 0, "R9"); drain();
    tx_allow = 1; mark();
    expect_at(1, 1, 0, 0, 1, 0, "R9"); drain();
    txd_in = 1; step(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule